// File: doc/BRIEF.md
# TU-12 to TUG-3 Two-Level Byte Interleaver

This block builds one TUG-3 from 21 TU-12 tributaries. Each tributary gives 4 bytes per row over 9 rows in every 125 µs frame. The block first interleaves three TU-12s byte by byte into a 12-column TUG-2. It then interleaves seven such groups into 84 data columns. Each row starts with two fixed-stuff columns, so a row is 86 columns and a frame is 774 bytes.

A frame starts when `frameStart` pulses. In each of the next 774 cycles the block handles one byte slot, walking the rows in order. For a data slot it raises exactly one bit of `tribRd` to name the tributary whose byte it takes. That source must hold its byte on `tribData` until the clock edge that ends the strobe. The chosen byte appears on `outData` one cycle later, with `outValid` high.

A two-bit multiframe index advances on every frame start and is exported. Sources use it to place their pointer and overhead bytes in the right frame of the four-frame multiframe. The content of the tributary bytes passes through unchanged and is not examined.

Top module: `tug3_interleaver`

## Requirements
- R1: While reset is asserted and after its release with no frame start, `outValid` is 0, `tribRd` is all zero and `mfIdx` is 0.
- R2: A `frameStart` pulse in cycle t makes cycles t+1 to t+774 the frame's byte slots. Slot s is row s/86, column s%86. The byte of slot s appears on `outData` in the following cycle with `outValid` high.
- R3: In every cycle `tribRd` has at most one bit set. In a data slot (column c ≥ 2), bit k is set with k = ((c-2)/7 mod 3)·7 + (c-2) mod 7. So the seven TUG-2 groups (k mod 7) cycle fastest and the TU-12 index within a group is k/7.
- R4: The output byte of a data slot equals bits [8k+7:8k] of `tribData` during that slot, where k is the tributary named in R3.
- R5: In the stuff slots (columns 0 and 1 of every row) no tributary is read and the output byte is 0x00.
- R6: `outSof` is high only with the output byte of slot 0 (row 0, column 0).
- R7: `mfIdx` advances by one modulo 4 on the clock edge that samples a `frameStart` pulse. It is unchanged on every other edge.
- R8: A `frameStart` during a frame in progress drops the rest of that frame. The next slot is row 0, column 0.
- R9: In a complete frame each tributary is read exactly 36 times, 4 times in every row.
- R10: After slot 773 of a frame, with no new `frameStart`, `outValid` stays 0 and `tribRd` stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle pulse that starts a 125 µs frame |
| tribData | input | 168 | Byte k (bits 8k+7:8k) is the current byte of tributary k |
| tribRd | output | 21 | One-hot read strobe for the tributary whose byte is taken this cycle |
| mfIdx | output | 2 | Position of the current frame within the four-frame multiframe |
| outData | output | 8 | TUG-3 byte stream |
| outValid | output | 1 | `outData` carries a frame byte |
| outSof | output | 1 | `outData` is the first byte of the frame |

## Verification
The assertions take `frameStart` to be a single-cycle pulse. They also take each source to hold its byte stable for the whole cycle in which its read strobe is high. The stimulus drives `frameStart` for exactly one cycle at a time. It changes each tributary byte only at the falling edge after a consumed strobe. It spaces frames both wider than 774 cycles, to cover idle gaps, and narrower, to cover a restart in mid-frame. The source bytes carry a per-tributary counter, so a wrong slot order or a lost or repeated read shows up in the output bytes.

// File: rtl/tug3_pkg.sv
package tug3_pkg;

  // Structure of the TUG-3 built from TU-12 tributaries
  localparam int NUM_TUG2   = 7;   // TUG-2 groups per TUG-3
  localparam int NUM_TU12   = 3;   // TU-12s per TUG-2
  localparam int TU_COLS    = 4;   // columns of one TU-12
  localparam int ROWS       = 9;   // rows per 125 us frame
  localparam int STUFF_COLS = 2;   // fixed-stuff columns per row
  localparam int BYTE_W     = 8;
  localparam int MF_LEN     = 4;   // frames per multiframe

  localparam int NUM_TRIB   = NUM_TUG2 * NUM_TU12;
  localparam int DATA_COLS  = NUM_TRIB * TU_COLS;
  localparam int TOTAL_COLS = DATA_COLS + STUFF_COLS;
  localparam int TRIB_W     = $clog2(NUM_TRIB);
  localparam int MF_W       = $clog2(MF_LEN);

  // Strobes from the slot sequencer to the byte path
  typedef struct packed {
    logic              slotValid;  // a frame slot is being served this cycle
    logic              slotStuff;  // the slot is a fixed-stuff column
    logic              slotFirst;  // row 0, column 0
    logic [TRIB_W-1:0] tribIdx;    // tributary owning a data slot
  } slot_strobe_t;

endpackage

// File: rtl/tug3_slot_ctrl.sv
module tug3_slot_ctrl
  import tug3_pkg::*;
#(
  parameter int NumTug2   = NUM_TUG2,
  parameter int NumTu12   = NUM_TU12,
  parameter int TuCols    = TU_COLS,
  parameter int Rows      = ROWS,
  parameter int StuffCols = STUFF_COLS,
  parameter int MfLen     = MF_LEN
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      frameStart,
  output slot_strobe_t              strobe,
  output logic [$clog2(MfLen)-1:0]  mfIdx
);

  localparam int TotalCols = NumTug2 * NumTu12 * TuCols + StuffCols;
  localparam int RowW      = $clog2(Rows);
  localparam int ColW      = $clog2(TotalCols);
  localparam int Tug2W     = $clog2(NumTug2);
  localparam int Tu12W     = $clog2(NumTu12);
  localparam int TuColW    = $clog2(TuCols);
  localparam int MfW       = $clog2(MfLen);

  logic              active;
  logic [RowW-1:0]   rowCnt;
  logic [ColW-1:0]   colCnt;
  logic [Tug2W-1:0]  tug2Cnt;
  logic [Tu12W-1:0]  tu12Cnt;
  logic [TuColW-1:0] tuColCnt;
  logic              inStuff;
  logic              lastCol;
  logic              lastRow;
  logic              lastTug2;
  logic              lastTu12;
  logic              lastTuCol;
  int                idxCalc;

  assign inStuff   = (int'(colCnt) < StuffCols);
  assign lastCol   = (int'(colCnt) == TotalCols - 1);
  assign lastRow   = (int'(rowCnt) == Rows - 1);
  assign lastTug2  = (int'(tug2Cnt) == NumTug2 - 1);
  assign lastTu12  = (int'(tu12Cnt) == NumTu12 - 1);
  assign lastTuCol = (int'(tuColCnt) == TuCols - 1);

  // Row and column position inside the 125 us frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      rowCnt <= '0;
      colCnt <= '0;
    end else if (frameStart) begin
      active <= 1'b1;
      rowCnt <= '0;
      colCnt <= '0;
    end else if (active) begin
      if (lastCol) begin
        colCnt <= '0;
        if (lastRow) begin
          active <= 1'b0;
          rowCnt <= '0;
        end else begin
          rowCnt <= rowCnt + 1'b1;
        end
      end else begin
        colCnt <= colCnt + 1'b1;
      end
    end
  end

  // Nested interleave counters: TUG-2 group fastest, then TU-12, then TU-12 column
  always_ff @(posedge clk) begin
    if (!rstN || frameStart) begin
      tug2Cnt  <= '0;
      tu12Cnt  <= '0;
      tuColCnt <= '0;
    end else if (active && !inStuff) begin
      if (lastTug2) begin
        tug2Cnt <= '0;
        if (lastTu12) begin
          tu12Cnt  <= '0;
          tuColCnt <= lastTuCol ? '0 : tuColCnt + 1'b1;
        end else begin
          tu12Cnt <= tu12Cnt + 1'b1;
        end
      end else begin
        tug2Cnt <= tug2Cnt + 1'b1;
      end
    end
  end

  // Multiframe position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mfIdx <= '0;
    end else if (frameStart) begin
      mfIdx <= (int'(mfIdx) == MfLen - 1) ? '0 : mfIdx + 1'b1;
    end
  end

  always_comb begin
    idxCalc          = int'(tu12Cnt) * NumTug2 + int'(tug2Cnt);
    strobe.slotValid = active;
    strobe.slotStuff = inStuff;
    strobe.slotFirst = active && (rowCnt == '0) && (colCnt == '0);
    strobe.tribIdx   = idxCalc[TRIB_W-1:0];
  end

endmodule

// File: rtl/tug3_byte_path.sv
module tug3_byte_path
  import tug3_pkg::*;
#(
  parameter int NumTrib = NUM_TRIB,
  parameter int ByteW   = BYTE_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  slot_strobe_t             strobe,
  input  logic [NumTrib*ByteW-1:0] tribData,
  output logic [NumTrib-1:0]       tribRd,
  output logic [ByteW-1:0]         outData,
  output logic                     outValid,
  output logic                     outSof
);

  logic             takeData;
  logic [ByteW-1:0] selByte;

  assign takeData = strobe.slotValid && !strobe.slotStuff;

  // One read strobe per tributary
  for (genvar k = 0; k < NumTrib; k++) begin : g_rd
    assign tribRd[k] = takeData && (int'(strobe.tribIdx) == k);
  end

  always_comb begin
    selByte = '0;
    for (int k = 0; k < NumTrib; k++) begin
      if (int'(strobe.tribIdx) == k) selByte = tribData[k*ByteW +: ByteW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= '0;
      outValid <= 1'b0;
      outSof   <= 1'b0;
    end else begin
      outData  <= takeData ? selByte : '0;
      outValid <= strobe.slotValid;
      outSof   <= strobe.slotValid && strobe.slotFirst;
    end
  end

endmodule

// File: rtl/tug3_interleaver.sv
module tug3_interleaver
  import tug3_pkg::*;
#(
  parameter int NumTrib = NUM_TRIB,
  parameter int ByteW   = BYTE_W,
  parameter int MfW     = MF_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameStart,
  input  logic [NumTrib*ByteW-1:0] tribData,
  output logic [NumTrib-1:0]       tribRd,
  output logic [MfW-1:0]           mfIdx,
  output logic [ByteW-1:0]         outData,
  output logic                     outValid,
  output logic                     outSof
);

  slot_strobe_t slotStrobe;

  tug3_slot_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .strobe     (slotStrobe),
    .mfIdx      (mfIdx)
  );

  tug3_byte_path #(
    .NumTrib (NumTrib),
    .ByteW   (ByteW)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (slotStrobe),
    .tribData (tribData),
    .tribRd   (tribRd),
    .outData  (outData),
    .outValid (outValid),
    .outSof   (outSof)
  );

endmodule

// File: rtl/tug3_interleaver_chk.sv
module tug3_interleaver_chk #(
  parameter int NumTrib = 21,
  parameter int ByteW   = 8,
  parameter int MfW     = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               frameStart,
  input logic [NumTrib-1:0] tribRd,
  input logic [MfW-1:0]     mfIdx,
  input logic [ByteW-1:0]   outData,
  input logic               outValid,
  input logic               outSof
);

  // R3
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tribRd));

  // R3
  rd_then_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|tribRd) |=> (outValid && !outSof));

  // R6
  sof_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> ##1 (outSof && outValid));

  // R5
  sof_is_stuff_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> (outValid && outData == '0));

  // R7
  mf_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (mfIdx == $past(mfIdx) + 1'b1));

  // R7
  mf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(mfIdx));

endmodule

bind tug3_interleaver tug3_interleaver_chk #(
  .NumTrib (NumTrib),
  .ByteW   (ByteW),
  .MfW     (MfW)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .tribRd     (tribRd),
  .mfIdx      (mfIdx),
  .outData    (outData),
  .outValid   (outValid),
  .outSof     (outSof)
);

// File: tb/tug3_interleaver_bench.sv
`timescale 1ns/1ps
module tug3_interleaver_bench;

  localparam int NTRIB  = 21;
  localparam int NCOL   = 86;
  localparam int NSLOT  = 9 * NCOL;
  localparam int NCYC   = 4200;

  logic               clk = 1'b0;
  logic               rstN;
  logic               frameStart;
  logic [NTRIB*8-1:0] tribData;
  logic [NTRIB-1:0]   tribRd;
  logic [1:0]         mfIdx;
  logic [7:0]         outData;
  logic               outValid;
  logic               outSof;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  int srcCnt  [NTRIB];
  int readCnt [NTRIB];

  always #10 clk = ~clk;

  tug3_interleaver u_tug3_interleaver (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .tribData(tribData),
    .tribRd(tribRd), .mfIdx(mfIdx), .outData(outData),
    .outValid(outValid), .outSof(outSof)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] srcByte(input int k);
    return 8'((k * 29 + srcCnt[k] * 7 + 3) & 255);
  endfunction

  task automatic driveSrc();
    for (int k = 0; k < NTRIB; k++) tribData[k*8 +: 8] = srcByte(k);
  endtask

  function automatic bit isStart(input int cyc);
    // idle gaps between frames, then a restart in mid-frame
    return (cyc == 2) || (cyc == 802) || (cyc == 1602) ||
           (cyc == 2000) || (cyc == 2900) || (cyc == 3680);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    bit refActive = 1'b0;
    int refSlot   = 0;
    int refMf     = 0;
    bit expVal    = 1'b0;
    bit expSof    = 1'b0;
    bit expStuff  = 1'b0;
    int expData   = 0;
    logic [NTRIB-1:0] pendRd = '0;

    rstN = 1'b0;
    frameStart = 1'b0;
    for (int k = 0; k < NTRIB; k++) begin srcCnt[k] = 0; readCnt[k] = 0; end
    driveSrc();

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    chk(tribRd == '0, "R1 tribRd in reset", int'(tribRd), 0);
    chk(mfIdx == 2'd0, "R1 mfIdx in reset", mfIdx, 0);
    rstN = 1'b1;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      // consume bytes taken at the last edge
      for (int k = 0; k < NTRIB; k++) if (pendRd[k]) srcCnt[k]++;
      driveSrc();

      // outputs from the previous slot
      if (cyc < 2) begin
        chk(outValid == 1'b0 && tribRd == '0, "R1 idle after reset", outValid, 0);
      end
      chk(outValid == expVal, expVal ? "R2 outValid" : "R10 outValid idle", outValid, expVal);
      if (expVal) begin
        chk(outSof == expSof, "R6 outSof", outSof, expSof);
        if (expStuff) chk(outData == 8'h00, "R5 stuff byte", outData, 0);
        else          chk(int'(outData) == expData, "R4 data byte", outData, expData);
      end else begin
        chk(outSof == 1'b0, "R6 outSof idle", outSof, 0);
      end
      chk(int'(mfIdx) == refMf, "R7 mfIdx", mfIdx, refMf);

      // current slot
      begin
        logic [NTRIB-1:0] eRd;
        int col;
        int d;
        int k;
        eRd = '0;
        expVal = refActive;
        expSof = 1'b0;
        expStuff = 1'b0;
        expData = 0;
        if (refActive) begin
          col = refSlot % NCOL;
          expSof = (refSlot == 0);
          if (col < 2) begin
            expStuff = 1'b1;
          end else begin
            d = col - 2;
            k = ((d / 7) % 3) * 7 + (d % 7);
            eRd[k] = 1'b1;
            expData = int'(srcByte(k));
            readCnt[k]++;
          end
        end
        chk(tribRd == eRd, refActive ? "R3 read strobe" : "R10 no read idle",
            int'(tribRd), int'(eRd));
      end
      pendRd = tribRd;

      // next-edge stimulus and model step
      frameStart = isStart(cyc);
      if (frameStart) begin
        if (refActive && refSlot != 0) begin
          // R8 the frame in progress is abandoned
        end
        refActive = 1'b1;
        refSlot = 0;
        refMf = (refMf + 1) % 4;
        for (int k = 0; k < NTRIB; k++) readCnt[k] = 0;
      end else if (refActive) begin
        refSlot++;
        if (refSlot == NSLOT) begin
          refActive = 1'b0;
          for (int k = 0; k < NTRIB; k++)
            chk(readCnt[k] == 36, "R9 reads per frame", readCnt[k], 36);
        end
      end
    end

    // R8 after the restart at cycle 2000 a full frame followed: stuff then first data at slot 2
    frameStart = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule